// File: doc/BRIEF.md
# Two-Dimensional Chained DMA Sequencer

This block generates the address stream and beat requests for one DMA channel. It runs by itself once started, so the processor core can keep executing while the channel works. It reads a transfer control block (a descriptor) from memory over a simple request/valid read port. It then walks either a linear run of addresses or a two-dimensional array. The walk uses separate start, count and signed stride values for the X (inner) and Y (outer) dimensions.

Each beat puts one address on the transfer port and holds it until the downstream side acknowledges it. When the last beat of a block is acknowledged, the block emits a one-cycle done pulse. If the descriptor's chain bit is set, the block then fetches the next descriptor from the pointer that the current descriptor carries and continues. The next descriptor may use a different mode and beat size. If the chain bit is clear, the channel returns to idle.

Top module: `dma2d_seq`

## Requirements
- R1: While idle, a high `start_i` starts a descriptor fetch. From the next cycle `desc_req_o` is high, and word k of the descriptor is requested at address `start_ptr_i + k`, k = 0..7. One word is taken per cycle in which `desc_valid_i` is high.
- R2: The descriptor words, by offset, are: 0 X start, 1 X count (low 16 bits), 2 X stride, 3 Y start, 4 Y count (low 16 bits), 5 Y stride, 6 control, 7 next-descriptor pointer. Control bit 0 enables chaining, bit 1 selects two-dimensional mode, and bits 3:2 give the beat size code.
- R3: While `xfer_req_o` is high and `xfer_ack_i` is low, `xfer_req_o` stays high and `xfer_addr_o` holds its value. The address moves only on an acknowledged beat.
- R4: In one-dimensional mode, beat k (k = 0..Xcount-1) has address Xstart + k*Xstride. The three Y words have no effect. A count of 0 behaves as 1.
- R5: In two-dimensional mode, the first address is Xstart + Ystart. Within a row the address steps by Xstride. After the last beat of a row it steps by Ystride instead. There are Xcount beats per row and Ycount rows.
- R6: Strides are two's complement, and all address arithmetic wraps modulo 2^32.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last beat of a block is acknowledged.
- R8: With the chain bit set, the fetch of the next descriptor at the word-7 pointer starts in the same cycle as `done_o`, with no further `start_i`.
- R9: With the chain bit clear, `busy_o` is low in the same cycle as `done_o`, and no further requests follow.
- R10: While a block runs, `xfer_size_o` carries that block's size code. Each chained block uses its own mode and size.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: `desc_req_o` and `xfer_req_o` are never high together. Both are high only while `busy_o` is high.
- R13: After reset, `busy_o`, `desc_req_o`, `xfer_req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a descriptor chain (honoured only when idle) |
| start_ptr_i | input | 32 | Address of the first descriptor |
| busy_o | output | 1 | Channel is fetching or transferring |
| desc_req_o | output | 1 | Descriptor word read request |
| desc_addr_o | output | 32 | Descriptor word address |
| desc_valid_i | input | 1 | Read data valid for the current request |
| desc_data_i | input | 32 | Descriptor word read data |
| xfer_req_o | output | 1 | Beat request |
| xfer_addr_o | output | 32 | Beat address |
| xfer_size_o | output | 2 | Beat size code of the running block |
| xfer_ack_i | input | 1 | Beat acknowledge |
| done_o | output | 1 | One-cycle end-of-block pulse |

## Verification
A start seen at a clock edge shows on `desc_req_o` and `desc_addr_o` after that edge. Each acknowledged beat moves `xfer_addr_o` at the same edge. `done_o` and the following chain fetch, or the drop of `busy_o`, appear one cycle after the final acknowledge. The bench drives inputs just after the rising edge and samples at the falling edge. It logs each beat in the half-cycle before the edge that accepts it, and it expects `done_o` exactly one sample later. The full address list, fetch addresses and size codes are computed in closed form from the descriptor fields. The bench sweeps small X/Y counts, both stride signs, address wrap and stalled acknowledges.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned CNT_W      = 16;
  parameter int unsigned SIZE_W     = 2;
  parameter int unsigned DESC_WORDS = 8;
  localparam int unsigned WIDX_W    = $clog2(DESC_WORDS);

  localparam logic [WIDX_W-1:0] W_XIDX = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_XCNT = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_XMOD = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_YIDX = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_YCNT = WIDX_W'(4);
  localparam logic [WIDX_W-1:0] W_YMOD = WIDX_W'(5);
  localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(6);
  localparam logic [WIDX_W-1:0] W_NEXT = WIDX_W'(7);

  localparam int unsigned CTL_CHAIN = 0;
  localparam int unsigned CTL_2D    = 1;
  localparam int unsigned CTL_SIZE  = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] x_idx;
    logic [CNT_W-1:0]  x_cnt;
    logic [ADDR_W-1:0] x_mod;
    logic [ADDR_W-1:0] y_idx;
    logic [CNT_W-1:0]  y_cnt;
    logic [ADDR_W-1:0] y_mod;
    logic              chain;
    logic              two_d;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] next_ptr;
  } desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RUN} seq_st_e;
endpackage

// File: rtl/dma2d_fetch.sv
module dma2d_fetch
  import dma2d_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output desc_t             desc_o,
  output logic              loaded_o
);
  logic              active_q;
  logic [WIDX_W-1:0] widx_q;
  logic [ADDR_W-1:0] base_q;
  logic              loaded_q;
  desc_t             desc_q;
  logic              take, last_word;

  assign take      = active_q && valid_i;
  assign last_word = (widx_q == WIDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      widx_q   <= '0;
      base_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= take && last_word;
      if (go_i) begin
        active_q <= 1'b1;
        widx_q   <= '0;
        base_q   <= ptr_i;
      end else if (take) begin
        if (last_word) active_q <= 1'b0;
        else           widx_q   <= widx_q + WIDX_W'(1);
      end
    end
  end

  // word offset picks the field it lands in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= '0;
    end else if (take) begin
      unique case (widx_q)
        W_XIDX: desc_q.x_idx <= data_i;
        W_XCNT: desc_q.x_cnt <= data_i[CNT_W-1:0];
        W_XMOD: desc_q.x_mod <= data_i;
        W_YIDX: desc_q.y_idx <= data_i;
        W_YCNT: desc_q.y_cnt <= data_i[CNT_W-1:0];
        W_YMOD: desc_q.y_mod <= data_i;
        W_CTRL: begin
          desc_q.chain <= data_i[CTL_CHAIN];
          desc_q.two_d <= data_i[CTL_2D];
          desc_q.size  <= data_i[CTL_SIZE +: SIZE_W];
        end
        W_NEXT: desc_q.next_ptr <= data_i;
        default: ;
      endcase
    end
  end

  assign req_o    = active_q;
  assign addr_o   = base_q + ADDR_W'(widx_q);
  assign desc_o   = desc_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] x_idx_i,
  input  logic [CNT_W-1:0]  x_cnt_i,
  input  logic [ADDR_W-1:0] x_mod_i,
  input  logic [ADDR_W-1:0] y_idx_i,
  input  logic [CNT_W-1:0]  y_cnt_i,
  input  logic [ADDR_W-1:0] y_mod_i,
  input  logic              two_d_i,
  input  logic              chain_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              chain_o,
  output logic [SIZE_W-1:0] size_o
);
  logic [ADDR_W-1:0] addr_q, xmod_q, ymod_q;
  logic [CNT_W-1:0]  xcnt_q, xrld_q, ycnt_q;
  logic              two_d_q, chain_q;
  logic [SIZE_W-1:0] size_q;
  logic              row_end, blk_end;

  assign row_end = (xcnt_q <= CNT_W'(1));
  assign blk_end = row_end && (!two_d_q || ycnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      xmod_q  <= '0;
      ymod_q  <= '0;
      xcnt_q  <= '0;
      xrld_q  <= '0;
      ycnt_q  <= '0;
      two_d_q <= 1'b0;
      chain_q <= 1'b0;
      size_q  <= '0;
    end else if (load_i) begin
      addr_q  <= two_d_i ? (x_idx_i + y_idx_i) : x_idx_i;
      xmod_q  <= x_mod_i;
      ymod_q  <= y_mod_i;
      xcnt_q  <= x_cnt_i;
      xrld_q  <= x_cnt_i;
      ycnt_q  <= y_cnt_i;
      two_d_q <= two_d_i;
      chain_q <= chain_i;
      size_q  <= size_i;
    end else if (step_i && !blk_end) begin
      if (row_end) begin
        addr_q <= addr_q + ymod_q;
        xcnt_q <= xrld_q;
        ycnt_q <= ycnt_q - CNT_W'(1);
      end else begin
        addr_q <= addr_q + xmod_q;
        xcnt_q <= xcnt_q - CNT_W'(1);
      end
    end
  end

  assign addr_o  = addr_q;
  assign last_o  = blk_end;
  assign chain_o = chain_q;
  assign size_o  = size_q;
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_ptr_i,
  output logic              busy_o,
  output logic              desc_req_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  input  logic              desc_valid_i,
  input  logic [ADDR_W-1:0] desc_data_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [SIZE_W-1:0] xfer_size_o,
  input  logic              xfer_ack_i,
  output logic              done_o
);
  seq_st_e           st_q, st_d;
  desc_t             desc;
  logic              loaded, step, blk_last, chain_on, fetch_go, done_q;
  logic [ADDR_W-1:0] fetch_ptr;

  assign step      = (st_q == ST_RUN) && xfer_ack_i;
  assign fetch_go  = ((st_q == ST_IDLE) && start_i) || (step && blk_last && chain_on);
  assign fetch_ptr = (st_q == ST_IDLE) ? start_ptr_i : desc.next_ptr;

  dma2d_fetch u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (fetch_go),
    .ptr_i    (fetch_ptr),
    .valid_i  (desc_valid_i),
    .data_i   (desc_data_i),
    .req_o    (desc_req_o),
    .addr_o   (desc_addr_o),
    .desc_o   (desc),
    .loaded_o (loaded)
  );

  dma2d_walker u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (loaded),
    .x_idx_i (desc.x_idx),
    .x_cnt_i (desc.x_cnt),
    .x_mod_i (desc.x_mod),
    .y_idx_i (desc.y_idx),
    .y_cnt_i (desc.y_cnt),
    .y_mod_i (desc.y_mod),
    .two_d_i (desc.two_d),
    .chain_i (desc.chain),
    .size_i  (desc.size),
    .step_i  (step),
    .addr_o  (xfer_addr_o),
    .last_o  (blk_last),
    .chain_o (chain_on),
    .size_o  (xfer_size_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: if (loaded)  st_d = ST_RUN;
      ST_RUN:   if (step && blk_last) st_d = chain_on ? ST_FETCH : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= step && blk_last;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign xfer_req_o = (st_q == ST_RUN);
  assign done_o     = done_q;
endmodule

// File: rtl/dma2d_seq_chk.sv
module dma2d_seq_chk
  import dma2d_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_ptr_i,
  input logic              busy_o,
  input logic              desc_req_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic              xfer_req_o,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic              xfer_ack_i,
  input logic              done_o
);
  assert_start_fetch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (desc_req_o && desc_addr_o == $past(start_ptr_i)));

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_addr_o)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (desc_req_o || !busy_o));

  assert_no_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_req_o && xfer_req_o));

  assert_req_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o || xfer_req_o) |-> busy_o);
endmodule

bind dma2d_seq dma2d_seq_chk u_chk (.*);

// File: tb/dma2d_seq_tb.sv
module dma2d_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        busy, dreq, dvalid, xreq, ack, done;
  logic [31:0] daddr, ddata, xaddr;
  logic [1:0]  xsize;

  always #4 clk = ~clk; // 125 MHz

  logic [31:0] mem [64];
  assign dvalid = dreq;
  assign ddata  = mem[daddr[5:0]];

  dma2d_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ptr_i(start_ptr),
    .busy_o(busy), .desc_req_o(dreq), .desc_addr_o(daddr),
    .desc_valid_i(dvalid), .desc_data_i(ddata),
    .xfer_req_o(xreq), .xfer_addr_o(xaddr), .xfer_size_o(xsize),
    .xfer_ack_i(ack), .done_o(done)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int ack_mode = 0;

  logic [31:0] exp_addr [1024];
  logic [1:0]  exp_size [1024];
  bit          exp_last [1024];
  logic [31:0] exp_fa   [64];
  int n_exp, n_fexp, n_blk, bi, fi, dcnt;
  bit done_pend;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 ack <= (ack_mode == 0) ? 1'b1 : (cyc % 3 != 0);
  end

  initial begin
    ack = 1'b1;
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit due;
      due = done_pend;
      done_pend = 1'b0;
      if (done) dcnt++;
      if (done || due) chk(done == due, "R7", "done pulse timing", done, due);
      if (dreq) begin
        chk(fi < n_fexp, "R11", "unexpected fetch", daddr, 0);
        if (fi < n_fexp) chk(daddr == exp_fa[fi], "R1/R8", "fetch address", daddr, exp_fa[fi]);
        fi++;
      end
      if (xreq && ack) begin
        chk(bi < n_exp, "R9", "extra beat", xaddr, 0);
        if (bi < n_exp) begin
          chk(xaddr == exp_addr[bi], "R4/R5/R6", "beat address", xaddr, exp_addr[bi]);
          chk(xsize == exp_size[bi], "R10", "beat size", xsize, exp_size[bi]);
          if (exp_last[bi]) done_pend = 1'b1;
        end
        bi++;
      end
    end
  end

  // descriptor into memory plus closed-form expectation
  task automatic add_desc(input int base, input logic [31:0] xi, input int xc,
                          input logic [31:0] xm, input logic [31:0] yi, input int yc,
                          input logic [31:0] ym, input bit chain, input bit two_d,
                          input logic [1:0] sz, input int nxt);
    int rows, cols;
    logic [31:0] b0, rstep;
    mem[base+0] = xi;  mem[base+1] = 32'(xc); mem[base+2] = xm;
    mem[base+3] = yi;  mem[base+4] = 32'(yc); mem[base+5] = ym;
    mem[base+6] = {28'hABCDE00, sz, two_d, chain};
    mem[base+7] = 32'(nxt);
    for (int k = 0; k < 8; k++) exp_fa[n_fexp++] = 32'(base + k);
    cols  = (xc < 1) ? 1 : xc;
    rows  = two_d ? ((yc < 1) ? 1 : yc) : 1;
    b0    = two_d ? xi + yi : xi;
    rstep = 32'(cols - 1) * xm + ym;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        exp_addr[n_exp] = b0 + 32'(r) * rstep + 32'(c) * xm;
        exp_size[n_exp] = sz;
        exp_last[n_exp] = (r == rows - 1) && (c == cols - 1);
        n_exp++;
      end
    n_blk++;
  endtask

  task automatic clear_exp;
    n_exp = 0; n_fexp = 0; n_blk = 0; bi = 0; fi = 0; dcnt = 0;
  endtask

  task automatic kick(input int ptr);
    @(posedge clk); #1 start = 1'b1; start_ptr = 32'(ptr);
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(bi == n_exp, tag, "beat count", bi, n_exp);
    chk(fi == n_fexp, tag, "fetch count", fi, n_fexp);
    chk(dcnt == n_blk, tag, "done count", dcnt, n_blk);
    chk(!busy && !xreq && !dreq, "R9", "idle after chain end", busy, 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    clear_exp();
    done_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !dreq && !xreq && !done, "R13", "reset outputs", {busy, dreq, xreq, done}, 0);
    #1 rst_n = 1'b1;

    // R4: 1D, Y words carry junk that must not matter; R2 layout
    clear_exp();
    add_desc(0, 32'h100, 5, 32'd4, 32'h55, 7, 32'h1000, 1'b0, 1'b0, 2'd1, 0);
    kick(0);
    wait_idle("R4");

    // R8 R10 R11: chain of three with differing mode/size, stalled acks, stray start
    ack_mode = 1;
    clear_exp();
    add_desc(8,  32'h10, 3, 32'd2, 32'h2000, 4, 32'hFFFF_FFFA, 1'b1, 1'b1, 2'd2, 16);
    add_desc(16, 32'h800, 4, 32'hFFFF_FFF8, 32'h0, 9, 32'h0, 1'b1, 1'b0, 2'd0, 24);
    add_desc(24, 32'h3000, 1, 32'd7, 32'h4, 3, 32'h40, 1'b0, 1'b1, 2'd3, 40);
    kick(8);
    repeat (14) @(posedge clk);
    #1 start = 1'b1; start_ptr = 32'd40; // R11: ignored while busy
    @(posedge clk); #1 start = 1'b0;
    wait_idle("R8");

    // R6: wrap through zero
    ack_mode = 0;
    clear_exp();
    add_desc(32, 32'hFFFF_FFFC, 3, 32'd4, 32'h0, 0, 32'h0, 1'b0, 1'b0, 2'd1, 0);
    kick(32);
    wait_idle("R6");

    // R5: sweep of X and Y counts in 2D, both ack patterns
    for (int m = 0; m < 2; m++)
      for (int xc = 1; xc <= 3; xc++)
        for (int yc = 1; yc <= 3; yc++) begin
          ack_mode = m;
          clear_exp();
          add_desc(0, 32'(16 * xc), xc, 32'd1, 32'(256 * yc), yc,
                   (m == 0) ? 32'h10 : 32'hFFFF_FFF0, 1'b0, 1'b1, 2'(xc), 0);
          kick(0);
          wait_idle("R5");
        end

    summary();
    $finish;
  end
endmodule